// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits in front of a synchronous pipelined SRAM array. It takes in an external address, and then produces the address that the array uses on each cycle. That address is either the one just loaded, or the next or current step of a four-beat burst. Every input is sampled on the rising clock edge. Outputs are registered and reflect the command taken at that edge.

Two address strobes start a burst. The processor strobe always opens a read burst and takes priority. The controller strobe opens a read or a write burst, as the write input says. When neither strobe is asserted, the advance input chooses between stepping to the next burst address and holding the current one. Only the two low address bits move. They follow a linear modulo-4 count or an XOR-interleaved count, as chosen by the order input when the burst is loaded. The upper bits keep their loaded value.

A new address may be loaded on any cycle, so random single accesses run back to back. The block has no data path, so it has no valid/ready handshake and no back-pressure. All pins are plain control and status pins.

Top module: `bsq_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets after that edge. `acc_valid` is 0, `acc_kind` is DESEL (3'd0) and `acc_addr` is all zeros. `acc_valid` stays 0 until an enabled strobe is taken.
- R2: Assume `ld_cpu_n`=0 and `sel_n`=0 at an edge. After that edge, `acc_addr` equals the sampled `addr_i` and `acc_kind` is RD_BEGIN (3'd1). This holds whatever the value of `wr_i`.
- R3: Assume `ld_cpu_n`=1, `ld_ctl_n`=0 and `sel_n`=0 at an edge. After that edge, `acc_addr` equals `addr_i`. `acc_kind` is WR_BEGIN (3'd5) if `wr_i`=1, and RD_BEGIN (3'd1) otherwise.
- R4: If both strobes are low in the same cycle, the processor strobe wins. The cycle is RD_BEGIN, even when `wr_i`=1.
- R5: During a burst, assume both strobes are high and `step_n`=0. The low two address bits move to the next burst position. `acc_kind` is WR_CONT (3'd6) if `wr_i`=1, and RD_CONT (3'd2) otherwise.
- R6: During a burst, assume both strobes are high and `step_n`=1. `acc_addr` is held. `acc_kind` is WR_SUSP (3'd7) if `wr_i`=1, and RD_SUSP (3'd3) otherwise.
- R7: If `order_i`=0 at the load, burst beat k has low bits (start + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R8: If `order_i`=1 at the load, burst beat k has low bits start XOR k. For example, a start of 01 gives 01, 00, 11, 10.
- R9: On the fifth beat of a burst, the low bits are back at the start value. The upper address bits never change within a burst.
- R10: If either strobe is low with `sel_n`=1, the cycle is a deselect. `acc_valid` becomes 0 and `acc_kind` becomes DESEL. Later cycles with both strobes high stay deselected, whatever `step_n` is.
- R11: A load may occur on any cycle, including inside a running burst. It takes effect on that same edge, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External address |
| sel_n | input | 1 | Chip enable, active low |
| ld_cpu_n | input | 1 | Processor address strobe, active low, read only |
| ld_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_i | input | 1 | Write intent from the write controls |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| acc_addr | output | ADDR_W | Array address for this cycle |
| acc_kind | output | 3 | Cycle kind; bit 2 set means write |
| acc_valid | output | 1 | Access in use this cycle |

## Verification
The internal state is the latched start bits, the beat count, the latched order and the burst-active flag. A wrong beat count or a wrong order bit shows on the very next advance, as bad low bits on `acc_addr`. A lost burst-active flag shows at once on the following idle or advance cycle, as a wrong `acc_valid`. The sweep covers every start value, both orders, both strobes and both write values. Each burst runs past its wrap, so any state error appears within five cycles of a load.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [2:0] {
    K_DESEL    = 3'd0,
    K_RD_BEGIN = 3'd1,
    K_RD_CONT  = 3'd2,
    K_RD_SUSP  = 3'd3,
    K_WR_BEGIN = 3'd5,
    K_WR_CONT  = 3'd6,
    K_WR_SUSP  = 3'd7
  } acc_kind_t;

  function automatic acc_kind_t with_dir(input logic is_wr, input logic [1:0] phase);
    return acc_kind_t'({is_wr, phase});
  endfunction
endpackage

// File: rtl/bsq_cmd_dec.sv
module bsq_cmd_dec (
  input  logic ld_cpu_n,
  input  logic ld_ctl_n,
  input  logic sel_n,
  input  logic step_n,
  input  logic wr_i,
  input  logic active,
  output logic load,
  output logic desel,
  output logic advance,
  output logic hold,
  output logic load_wr
);
  logic any_strobe;

  always_comb begin
    any_strobe = !ld_cpu_n || !ld_ctl_n;
    load       = any_strobe && !sel_n;
    desel      = any_strobe && sel_n;
    // processor strobe wins and forces a read
    load_wr    = load && ld_cpu_n && wr_i;
    advance    = !any_strobe && active && !step_n;
    hold       = !any_strobe && active && step_n;
  end
endmodule

// File: rtl/bsq_burst_ctr.sv
module bsq_burst_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic [BURST_W-1:0] start_i,
  input  logic               order_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] beat_q;
  logic               order_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= 1'b0;
    end else if (load) begin
      start_q <= start_i;
      beat_q  <= '0;
      order_q <= order_i;
    end else if (advance) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  logic [BURST_W-1:0] lin_v;
  logic [BURST_W-1:0] ilv_v;

  assign lin_v = start_q + beat_q;

  genvar b;
  generate
    for (b = 0; b < BURST_W; b++) begin : g_ilv
      assign ilv_v[b] = start_q[b] ^ beat_q[b];
    end
  endgenerate

  assign low_o = order_q ? ilv_v : lin_v;
endmodule

// File: rtl/bsq_seq.sv
module bsq_seq #(
  parameter int ADDR_W  = 12,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_n,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              step_n,
  input  logic              wr_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [2:0]        acc_kind,
  output logic              acc_valid
);
  import bsq_pkg::*;

  localparam int HI_W = ADDR_W - BURST_W;

  logic load, desel, advance, hold, load_wr;
  logic active_q;
  logic [HI_W-1:0] hi_q;
  logic [BURST_W-1:0] low_v;
  acc_kind_t kind_q;

  bsq_cmd_dec u_dec (
    .ld_cpu_n (ld_cpu_n),
    .ld_ctl_n (ld_ctl_n),
    .sel_n    (sel_n),
    .step_n   (step_n),
    .wr_i     (wr_i),
    .active   (active_q),
    .load     (load),
    .desel    (desel),
    .advance  (advance),
    .hold     (hold),
    .load_wr  (load_wr)
  );

  bsq_burst_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (advance),
    .start_i (addr_i[BURST_W-1:0]),
    .order_i (order_i),
    .low_o   (low_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      acc_valid <= 1'b0;
      hi_q      <= '0;
      kind_q    <= K_DESEL;
    end else if (load) begin
      active_q  <= 1'b1;
      acc_valid <= 1'b1;
      hi_q      <= addr_i[ADDR_W-1:BURST_W];
      kind_q    <= with_dir(load_wr, 2'd1);
    end else if (desel) begin
      active_q  <= 1'b0;
      acc_valid <= 1'b0;
      kind_q    <= K_DESEL;
    end else if (advance) begin
      acc_valid <= 1'b1;
      kind_q    <= with_dir(wr_i, 2'd2);
    end else if (hold) begin
      acc_valid <= 1'b1;
      kind_q    <= with_dir(wr_i, 2'd3);
    end else begin
      acc_valid <= 1'b0;
      kind_q    <= K_DESEL;
    end
  end

  assign acc_addr = {hi_q, low_v};
  assign acc_kind = kind_q;
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int ADDR_W  = 12,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              sel_n,
  input logic              ld_cpu_n,
  input logic              ld_ctl_n,
  input logic              step_n,
  input logic              wr_i,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [2:0]        acc_kind,
  input logic              acc_valid
);
  logic idle_in;
  assign idle_in = ld_cpu_n && ld_ctl_n;

  a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && !sel_n) |=> (acc_kind == 3'd1 && acc_addr == $past(addr_i) && acc_valid));

  a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cpu_n && !ld_ctl_n && !sel_n) |=>
      (acc_addr == $past(addr_i) && acc_kind[2] == $past(wr_i) && acc_kind[1:0] == 2'd1));

  a_r6_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_in && step_n && acc_valid) |=> ($stable(acc_addr) && acc_valid && acc_kind[1:0] == 2'd3));

  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_in && acc_valid) |=> (acc_addr[ADDR_W-1:BURST_W] == $past(acc_addr[ADDR_W-1:BURST_W])));

  a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_in && sel_n) |=> (!acc_valid && acc_kind == 3'd0));

  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_in && !acc_valid) |=> !acc_valid);
endmodule

bind bsq_seq bsq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .sel_n(sel_n),
  .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n), .wr_i(wr_i),
  .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_valid(acc_valid)
);

// File: tb/sim_bsq_seq.sv
module sim_bsq_seq;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic sel_n = 1'b1, ld_cpu_n = 1'b1, ld_ctl_n = 1'b1, step_n = 1'b1;
  logic wr_i = 1'b0, order_i = 1'b0;
  logic [AW-1:0] acc_addr;
  logic [2:0] acc_kind;
  logic acc_valid;

  int checks = 0, errors = 0;

  // model state
  logic [AW-1:0] m_base;
  int m_beat;
  logic m_ord, m_act;

  always #5 clk = ~clk;

  bsq_seq #(.ADDR_W(AW), .BURST_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .sel_n(sel_n),
    .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n),
    .wr_i(wr_i), .order_i(order_i),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_valid(acc_valid)
  );

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] s, k, lo;
    s = m_base[1:0];
    k = 2'(m_beat);
    lo = m_ord ? (s ^ k) : 2'(s + k);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, logic [2:0] ek, logic ev);
    checks++;
    if (acc_valid !== ev || acc_kind !== ek || (ev && acc_addr !== ea)) begin
      errors++;
      $display("FAIL %s addr=%h kind=%0d valid=%0b exp addr=%h kind=%0d valid=%0b",
               req, acc_addr, acc_kind, acc_valid, ea, ek, ev);
    end
  endtask

  // one cycle: drive, clock, update model, compare
  task automatic cyc(string req, logic cpu, logic ctl, logic sel, logic stp,
                     logic wr, logic ord, logic [AW-1:0] a);
    logic [2:0] ek;
    logic ev;
    ld_cpu_n = cpu; ld_ctl_n = ctl; sel_n = sel; step_n = stp;
    wr_i = wr; order_i = ord; addr_i = a;
    @(posedge clk); #2;
    if ((!cpu || !ctl) && !sel) begin
      m_base = a; m_beat = 0; m_ord = ord; m_act = 1'b1;
      ek = (!cpu) ? 3'd1 : (wr ? 3'd5 : 3'd1); ev = 1'b1;
    end else if (!cpu || !ctl) begin
      m_act = 1'b0; ek = 3'd0; ev = 1'b0;
    end else if (m_act && !stp) begin
      m_beat = (m_beat + 1) % 4; ek = wr ? 3'd6 : 3'd2; ev = 1'b1;
    end else if (m_act) begin
      ek = wr ? 3'd7 : 3'd3; ev = 1'b1;
    end else begin
      ek = 3'd0; ev = 1'b0;
    end
    check(req, exp_addr(), ek, ev);
  endtask

  initial begin
    m_base = '0; m_beat = 0; m_ord = 1'b0; m_act = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    checks++;
    if (acc_valid !== 1'b0 || acc_kind !== 3'd0 || acc_addr !== '0) begin
      errors++;
      $display("FAIL R1 addr=%h kind=%0d valid=%0b exp 0/0/0", acc_addr, acc_kind, acc_valid);
    end
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: idle cycles keep valid low
    cyc("R1", 1, 1, 0, 0, 1, 0, 12'h3a5);
    cyc("R1", 1, 1, 0, 1, 0, 0, 12'h3a5);

    // sweep: order x start x strobe x write (R2 R3 R5 R6 R7 R8 R9)
    for (int ord = 0; ord < 2; ord++)
      for (int st = 0; st < 4; st++)
        for (int sb = 0; sb < 2; sb++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [AW-1:0] a;
            a = AW'((st + 4 * (ord * 16 + st * 4 + sb * 2 + wr + 5)) * 7) & ~AW'(3) | AW'(st);
            if (sb == 0) cyc("R2", 0, 1, 0, 1, 1'(wr), 1'(ord), a);
            else         cyc("R3", 1, 0, 0, 1, 1'(wr), 1'(ord), a);
            for (int k = 0; k < 5; k++)
              cyc(ord ? "R8" : "R7", 1, 1, 0, 0, 1'(wr), 1'(~ord), ~a);
            // after 5 beats low bits equal start+1 step; check wrap at beat 4 covered above
            cyc("R6", 1, 1, 1, 1, 1'(wr), 1'(ord), ~a);
            cyc("R9", 1, 1, 0, 0, 1'(~wr), 1'(ord), a);
          end

    // R4: both strobes low, write requested -> read begin
    cyc("R4", 0, 0, 0, 1, 1, 0, 12'h7c6);
    cyc("R5", 1, 1, 0, 0, 0, 1, 12'h000);
    // R10: deselect then advances ignored
    cyc("R10", 1, 0, 1, 0, 1, 0, 12'h111);
    cyc("R10", 1, 1, 0, 0, 1, 0, 12'h222);
    cyc("R10", 1, 1, 0, 1, 0, 0, 12'h222);
    cyc("R10", 0, 1, 1, 0, 0, 0, 12'h333);
    // R11: back-to-back random loads and a load mid-burst
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 613 + 91);
      cyc("R11", 1'(i % 3 == 0), 1'(i % 3 != 0), 0, 1'(i[0]), 1'(i[1]), 1'(i[2]), a);
      cyc("R11", 1, 1, 0, 0, 1'(i[1]), 0, a);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule